// File: doc/BRIEF.md
# Synchronous Burst SRAM with Flow-Through Reads

This block models a single-clock synchronous SRAM whose accesses run in bursts of up to four words. The word is 36 bits wide, organised as four byte lanes, and each lane carries one parity bit. A burst is opened by one of two start strobes. The starting address is captured at that edge. A 2-bit counter then supplies the low address bits of the following beats while the step input is held low. The step order is selectable: linear wrap-around or an exclusive-or pattern. The upper address bits stay fixed for the whole burst.

All command, address and write inputs are sampled on the rising clock edge. Reads are flow-through: the word at the address registered at an edge appears on `rdata` during the cycle that follows, with no extra output register. The output enable and the sleep input act combinationally on the output. Sleep also freezes the burst state and blocks every command, and the memory contents are kept.

Top module: `sync_burst_sram`

## Requirements
- R1: A cycle is selected only when `sel_n`=0, `sel2_n`=0 and `sel2`=1. If `strb_c_n` is low in a cycle that is not selected, the burst ends. `rdata_vld` then stays 0 and no write takes place until a new burst starts.
- R2: `strb_p_n` low starts a read burst only while `sel_n` is low, and its write inputs are ignored in that cycle. While `sel_n` is high, `strb_p_n` has no effect and the running burst continues unchanged. If both strobes are low while `sel_n` is low, `strb_p_n` wins.
- R3: `strb_c_n` low in a selected cycle loads `addr` as the burst start. That cycle is a write if any lane is enabled and a read otherwise.
- R4: In a running burst with no strobe, `step_n`=0 advances the 2-bit beat count by one and wraps modulo 4. `step_n`=1 holds the current address.
- R5: With `ilv`=0 (linear order), the low two address bits equal the start bits plus the beat count, modulo 4. The upper bits stay fixed.
- R6: With `ilv`=1 (interleaved order), the low two address bits equal the start bits XOR the beat count.
- R7: `lane_wr_n[i]`=0 writes lane i. That lane is data bits [8i+7:8i] together with parity bit 32+i. Lanes whose enable is high keep their stored value.
- R8: `all_wr_n`=0 writes all four lanes, whatever `lane_wr_n` holds.
- R9: Read data is flow-through. After the edge that registers a read address, or that advances to one, that word is on `rdata` with `rdata_vld`=1 in the same cycle.
- R10: `out_en_n`=1 forces `rdata_vld`=0 and `rdata`=0 combinationally, with no clock edge needed. Clearing it brings the word back at once.
- R11: While `sleep`=1, no command, step or write is accepted, and `rdata_vld`=0. The memory and the burst state are kept, so the burst resumes after `sleep` falls.
- R12: After a synchronous reset (`rst_n`=0 at an edge), no burst is open and `rdata_vld`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Word address, captured when a burst starts |
| wdata | input | 36 | Write word: bytes in [31:0], lane parity in [35:32] |
| sel_n | input | 1 | Primary select, active low |
| sel2_n | input | 1 | Expansion select, active low |
| sel2 | input | 1 | Expansion select, active high |
| strb_p_n | input | 1 | Read-start strobe, gated by `sel_n` |
| strb_c_n | input | 1 | Read/write start strobe |
| step_n | input | 1 | Burst step, active low |
| lane_wr_n | input | 4 | Per-lane write enables, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| out_en_n | input | 1 | Output enable, active low, combinational |
| sleep | input | 1 | Snooze: blocks commands and output |
| rdata | output | 36 | Read word, zero when not driven |
| rdata_vld | output | 1 | High while `rdata` is driven |

## Verification
Two functions can fall in the same cycle. In one case a read-start strobe arrives together with asserted write enables. In the other, a burst step coincides with a write, so the write lands on the advanced address that is also read back later. The bench drives a read start with every write enable low and expects the old word back in the same cycle. It runs a write burst whose beats fill consecutive addresses, then reads them back in both orders. A further coincidence is a start strobe arriving while sleep or a deselect is active; the bench judges it by reading the target word afterwards.

// File: rtl/sbs_pkg.sv
// Package: shared types and the burst-order function for the burst SRAM.
// Assumes a 2-bit beat counter; the order function depends on that width.
package sbs_pkg;
    localparam int BURST_W = 2;

    // Command decoded from the strobes and selects in one cycle.
    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,   // nothing accepted (sleep)
        CMD_CONT  = 2'd1,   // continue or hold a running burst
        CMD_START = 2'd2,   // open a new burst at addr
        CMD_DESEL = 2'd3    // close the burst
    } sbs_cmd_e;

    // Low address bits of a beat: add for linear, XOR for interleaved.
    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] cnt,
        input logic               interleave
    );
        return interleave ? (start ^ cnt) : (start + cnt);
    endfunction
endpackage

// File: rtl/sbs_cmd_decode.sv
// Module: command decode.
// Turns the selects, the two start strobes, sleep and the write enables into
// one command and a per-lane write request. Purely combinational.
// Assumes: the read-start strobe takes priority over the read/write strobe
// when the primary select is low; a read-start cycle never writes.
module sbs_cmd_decode
    import sbs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             sel_n,
    input  logic             sel2_n,
    input  logic             sel2,
    input  logic             strb_p_n,
    input  logic             strb_c_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic             all_wr_n,
    input  logic             sleep,
    output sbs_cmd_e         cmd,
    output logic [LANES-1:0] lane_req
);
    logic selected;
    logic p_start;

    // Full select and whether the read-start strobe is live this cycle.
    always_comb begin
        selected = !sel_n && !sel2_n && sel2;
        p_start  = !strb_p_n && !sel_n;
    end

    // Command priority: sleep, read-start, read/write start, continue.
    always_comb begin
        if (sleep) begin
            cmd = CMD_HOLD;
        end else if (p_start || !strb_c_n) begin
            cmd = selected ? CMD_START : CMD_DESEL;
        end else begin
            cmd = CMD_CONT;
        end
    end

    // Lane write request: global write overrides, read-start masks all.
    always_comb begin
        if (sleep || p_start || cmd == CMD_DESEL) begin
            lane_req = '0;
        end else if (!all_wr_n) begin
            lane_req = '1;
        end else begin
            lane_req = ~lane_wr_n;
        end
    end
endmodule

// File: rtl/sbs_burst_ctrl.sv
// Module: burst address control.
// Holds the start address, the beat counter and the open/read flags. Gives
// the current address (read side, registered) and the address being taken
// at the coming edge (write side).
// Assumes: the counter is BURST_W bits and ADDR_W > BURST_W.
module sbs_burst_ctrl
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sbs_cmd_e          cmd,
    input  logic              step_n,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              wr_cycle,
    output logic              accept,
    output logic              active,
    output logic              rd_mode,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] nxt_addr
);
    logic [ADDR_W-1:0]  base_q, base_d;
    logic [BURST_W-1:0] cnt_q, cnt_d;
    logic               act_q, act_d;
    logic               rd_q, rd_d;

    // Next-state for start address, beat count and flags.
    always_comb begin
        base_d = base_q;
        cnt_d  = cnt_q;
        act_d  = act_q;
        rd_d   = rd_q;
        accept = 1'b0;
        case (cmd)
            CMD_START: begin
                base_d = addr_in;
                cnt_d  = '0;
                act_d  = 1'b1;
                accept = 1'b1;
            end
            CMD_CONT: begin
                if (act_q) begin
                    accept = 1'b1;
                    if (!step_n) begin
                        cnt_d = cnt_q + BURST_W'(1);
                    end
                end
            end
            CMD_DESEL: begin
                act_d = 1'b0;
                rd_d  = 1'b0;
            end
            default: begin
            end
        endcase
        if (accept) begin
            rd_d = !wr_cycle;
        end
    end

    // Burst state registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            act_q  <= 1'b0;
            rd_q   <= 1'b0;
        end else begin
            base_q <= base_d;
            cnt_q  <= cnt_d;
            act_q  <= act_d;
            rd_q   <= rd_d;
        end
    end

    // Address composition: fixed upper bits, ordered low bits.
    always_comb begin
        cur_addr = {base_q[ADDR_W-1:BURST_W],
                    burst_low(base_q[BURST_W-1:0], cnt_q, ilv)};
        nxt_addr = {base_d[ADDR_W-1:BURST_W],
                    burst_low(base_d[BURST_W-1:0], cnt_d, ilv)};
        active   = act_q;
        rd_mode  = rd_q;
    end

    // R4
    step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_CONT && act_q && step_n) |=> ($stable(cnt_q) && $stable(base_q)));

    // R4
    step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_CONT && act_q && !step_n) |=> (cnt_q == $past(cnt_q) + BURST_W'(1)));

    // R11
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_HOLD) |=> ($stable(cnt_q) && $stable(base_q) && $stable(act_q) && $stable(rd_q)));
endmodule

// File: rtl/sbs_lane_mem.sv
// Module: lane-sliced storage.
// One array per byte lane, each BYTE_W data bits plus one parity bit.
// Writes land at the edge on waddr; the read port is combinational on raddr.
// Assumes: data bytes packed low, parity bits packed above all data bytes.
module sbs_lane_mem #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                         clk,
    input  logic [LANES-1:0]             lane_we,
    input  logic [ADDR_W-1:0]            waddr,
    input  logic [LANES*(BYTE_W+1)-1:0]  wdata,
    input  logic [ADDR_W-1:0]            raddr,
    output logic [LANES*(BYTE_W+1)-1:0]  rdata
);
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int PAR_BASE = LANES * BYTE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W:0] store [DEPTH];
        logic [BYTE_W:0] rd_word;

        // Lane write: parity and data bits together.
        always_ff @(posedge clk) begin
            if (lane_we[g]) begin
                store[waddr] <= {wdata[PAR_BASE+g], wdata[g*BYTE_W +: BYTE_W]};
            end
        end

        // Flow-through read of this lane.
        always_comb begin
            rd_word                    = store[raddr];
            rdata[g*BYTE_W +: BYTE_W]  = rd_word[BYTE_W-1:0];
            rdata[PAR_BASE+g]          = rd_word[BYTE_W];
        end
    end
endmodule

// File: rtl/sync_burst_sram.sv
// Module: synchronous burst SRAM top.
// Wires decode, burst control and lane storage; gates the read port with
// the combinational output enable and sleep.
// Assumes: memory contents are not reset; rdata reads zero when not driven.
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [LANES*(BYTE_W+1)-1:0] wdata,
    input  logic                        sel_n,
    input  logic                        sel2_n,
    input  logic                        sel2,
    input  logic                        strb_p_n,
    input  logic                        strb_c_n,
    input  logic                        step_n,
    input  logic [LANES-1:0]            lane_wr_n,
    input  logic                        all_wr_n,
    input  logic                        ilv,
    input  logic                        out_en_n,
    input  logic                        sleep,
    output logic [LANES*(BYTE_W+1)-1:0] rdata,
    output logic                        rdata_vld
);
    localparam int DATA_W = LANES * (BYTE_W + 1);

    sbs_cmd_e            cmd;
    logic [LANES-1:0]    lane_req;
    logic [LANES-1:0]    lane_we;
    logic                accept;
    logic                active;
    logic                rd_mode;
    logic [ADDR_W-1:0]   cur_addr;
    logic [ADDR_W-1:0]   nxt_addr;
    logic [DATA_W-1:0]   mem_rd;

    sbs_cmd_decode #(.LANES(LANES)) u_dec (
        .sel_n     (sel_n),
        .sel2_n    (sel2_n),
        .sel2      (sel2),
        .strb_p_n  (strb_p_n),
        .strb_c_n  (strb_c_n),
        .lane_wr_n (lane_wr_n),
        .all_wr_n  (all_wr_n),
        .sleep     (sleep),
        .cmd       (cmd),
        .lane_req  (lane_req)
    );

    sbs_burst_ctrl #(.ADDR_W(ADDR_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .step_n   (step_n),
        .ilv      (ilv),
        .addr_in  (addr),
        .wr_cycle (|lane_req),
        .accept   (accept),
        .active   (active),
        .rd_mode  (rd_mode),
        .cur_addr (cur_addr),
        .nxt_addr (nxt_addr)
    );

    // Writes happen only in cycles the burst control accepts.
    always_comb begin
        lane_we = lane_req & {LANES{accept}};
    end

    sbs_lane_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)) u_mem (
        .clk     (clk),
        .lane_we (lane_we),
        .waddr   (nxt_addr),
        .wdata   (wdata),
        .raddr   (cur_addr),
        .rdata   (mem_rd)
    );

    // Output gating: open read burst, output enabled, not asleep.
    always_comb begin
        rdata_vld = active && rd_mode && !out_en_n && !sleep;
        rdata     = rdata_vld ? mem_rd : '0;
    end

    // R1
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_c_n && (sel_n || sel2_n || !sel2) && (strb_p_n || sel_n) && !sleep)
        |=> !rdata_vld);

    // R2
    p_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_p_n && sel_n && strb_c_n && !sleep)
        |=> $stable(cur_addr[ADDR_W-1:BURST_W]));
endmodule

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;
    localparam int AW = 6;

    typedef struct packed {
        logic        ilv;
        logic        sp_n;
        logic        sc_n;
        logic        st_n;
        logic        gw_n;
        logic [3:0]  bw_n;
        logic [5:0]  a;
        logic [35:0] d;
        logic        ev;
        logic [35:0] ed;
    } vec_t;

    localparam logic [35:0] D0 = 36'hA11111111;
    localparam logic [35:0] D1 = 36'hB22222222;
    localparam logic [35:0] D2 = 36'hC33333333;
    localparam logic [35:0] D3 = 36'hD44444444;
    localparam logic [35:0] DX = 36'h123456789;

    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b1,1'b0,1'b1,1'b0,4'hF,6'd8, D0,1'b0,36'h0},          // write burst start
        '{1'b0,1'b1,1'b1,1'b0,1'b0,4'hF,6'd0, D1,1'b0,36'h0},          // step+write -> 9
        '{1'b0,1'b1,1'b1,1'b0,1'b0,4'hF,6'd0, D2,1'b0,36'h0},          // -> 10
        '{1'b0,1'b1,1'b1,1'b0,1'b0,4'hF,6'd0, D3,1'b0,36'h0},          // -> 11
        '{1'b0,1'b0,1'b1,1'b1,1'b1,4'hF,6'd9, 36'h0,1'b1,D1},          // linear read at 9
        '{1'b0,1'b1,1'b1,1'b0,1'b1,4'hF,6'd0, 36'h0,1'b1,D2},
        '{1'b0,1'b1,1'b1,1'b0,1'b1,4'hF,6'd0, 36'h0,1'b1,D3},
        '{1'b0,1'b1,1'b1,1'b0,1'b1,4'hF,6'd0, 36'h0,1'b1,D0},          // wrap
        '{1'b0,1'b1,1'b1,1'b1,1'b1,4'hF,6'd0, 36'h0,1'b1,D0},          // hold
        '{1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,6'd9, 36'h0,1'b1,D1},          // interleaved at 9
        '{1'b1,1'b1,1'b1,1'b0,1'b1,4'hF,6'd0, 36'h0,1'b1,D0},
        '{1'b1,1'b1,1'b1,1'b0,1'b1,4'hF,6'd0, 36'h0,1'b1,D3},
        '{1'b1,1'b1,1'b1,1'b0,1'b1,4'hF,6'd0, 36'h0,1'b1,D2},
        '{1'b0,1'b1,1'b0,1'b1,1'b0,4'hF,6'd12,36'h0,1'b0,36'h0},       // clear 12
        '{1'b0,1'b1,1'b0,1'b1,1'b1,4'hA,6'd12,36'hFFFFFFFFF,1'b0,36'h0}, // lanes 0,2
        '{1'b0,1'b0,1'b1,1'b1,1'b1,4'hF,6'd12,36'h0,1'b1,36'h500FF00FF},
        '{1'b0,1'b1,1'b0,1'b1,1'b0,4'hF,6'd12,DX,1'b0,36'h0},          // global write
        '{1'b0,1'b0,1'b1,1'b1,1'b1,4'hF,6'd12,36'h0,1'b1,DX},
        '{1'b0,1'b0,1'b1,1'b1,1'b0,4'h0,6'd12,36'h0,1'b1,DX}           // read-start ignores writes
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [35:0]   wdata = '0;
    logic          sel_n = 1'b0, sel2_n = 1'b0, sel2 = 1'b1;
    logic          strb_p_n = 1'b1, strb_c_n = 1'b1, step_n = 1'b1;
    logic [3:0]    lane_wr_n = 4'hF;
    logic          all_wr_n = 1'b1, ilv = 1'b0, out_en_n = 1'b0, sleep = 1'b0;
    logic [35:0]   rdata;
    logic          rdata_vld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .sel_n(sel_n), .sel2_n(sel2_n), .sel2(sel2),
        .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .step_n(step_n),
        .lane_wr_n(lane_wr_n), .all_wr_n(all_wr_n), .ilv(ilv),
        .out_en_n(out_en_n), .sleep(sleep),
        .rdata(rdata), .rdata_vld(rdata_vld)
    );

    task automatic chk(input string tag, input logic ev, input logic [35:0] ed);
        checks++;
        if (rdata_vld !== ev || rdata !== ed) begin
            errors++;
            $display("FAIL %s: actual vld=%0b data=%h expected vld=%0b data=%h",
                     tag, rdata_vld, rdata, ev, ed);
        end
    endtask

    task automatic drv(input logic i, input logic sp, input logic sc, input logic st,
                       input logic gw, input logic [3:0] bw, input logic [5:0] a,
                       input logic [35:0] d);
        ilv = i; strb_p_n = sp; strb_c_n = sc; step_n = st;
        all_wr_n = gw; lane_wr_n = bw; addr = a; wdata = d;
    endtask

    task automatic cyc_chk(input string tag, input logic ev, input logic [35:0] ed);
        @(posedge clk);
        #2;
        chk(tag, ev, ed);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R12 after reset", 1'b0, 36'h0);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            string tag;
            drv(TBL[k].ilv, TBL[k].sp_n, TBL[k].sc_n, TBL[k].st_n,
                TBL[k].gw_n, TBL[k].bw_n, TBL[k].a, TBL[k].d);
            if (k < 4)       tag = $sformatf("R3 R4 row %0d", k);
            else if (k < 9)  tag = $sformatf("R5 R9 R4 row %0d", k);
            else if (k < 13) tag = $sformatf("R6 row %0d", k);
            else if (k < 16) tag = $sformatf("R7 row %0d", k);
            else if (k < 18) tag = $sformatf("R8 row %0d", k);
            else             tag = $sformatf("R2 row %0d", k);
            cyc_chk(tag, TBL[k].ev, TBL[k].ed);
        end

        // R10: output enable acts without a clock edge
        drv(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 6'd0, 36'h0);
        out_en_n = 1'b1;
        #1 chk("R10 disabled", 1'b0, 36'h0);
        out_en_n = 1'b0;
        #1 chk("R10 re-enabled", 1'b1, DX);

        // R2: read-start strobe with primary select high is ignored
        sel_n = 1'b1;
        drv(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 6'd8, 36'h0);
        cyc_chk("R2 strobe ignored", 1'b1, DX);
        sel_n = 1'b0;

        // R1: deselect by expansion selects
        sel2 = 1'b0;
        drv(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 6'd8, 36'h0);
        cyc_chk("R1 deselect sel2", 1'b0, 36'h0);
        sel2 = 1'b1; sel2_n = 1'b1;
        drv(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'hF, 6'd12, 36'h0);
        cyc_chk("R1 deselected write", 1'b0, 36'h0);
        sel2_n = 1'b0;
        drv(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 6'd12, 36'h0);
        cyc_chk("R1 write blocked", 1'b1, DX);

        // R11: sleep blocks commands and output, keeps state
        drv(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 6'd8, 36'h0);
        cyc_chk("R11 setup read", 1'b1, D0);
        sleep = 1'b1;
        drv(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF, 6'd8, 36'h0);
        cyc_chk("R11 asleep", 1'b0, 36'h0);
        sleep = 1'b0;
        drv(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 6'd0, 36'h0);
        cyc_chk("R11 resumed", 1'b1, D0);

        // R3: read/write strobe with no write enable opens a read
        drv(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 6'd10, 36'h0);
        cyc_chk("R3 read start", 1'b1, D2);

        // R12: reset in mid-burst
        rst_n = 1'b0;
        drv(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 6'd0, 36'h0);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc_chk("R12 mid-run reset", 1'b0, 36'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule